// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider Controller

This block sits in the feedback path of a frequency synthesizer and divides the output of an external dual-modulus prescaler by a programmable count. It is clocked by the prescaled signal. It runs a main down-counter loaded with N and a swallow down-counter loaded with A in parallel. It also drives a modulus-select line back to the prescaler. While the select line is low, the prescaler divides by P+1. While it is high, the prescaler divides by P.

Each divide cycle has N prescaled clocks. The first A of them run at modulus P+1 and the rest run at modulus P. Together the prescaler and this block therefore divide the oscillator frequency by N·P + A. A one-clock feedback pulse marks the terminal count of the main counter. That pulse drives the phase comparison and can also be used as a plain divide-by-N output. New N and A values are taken only when the counters reload, so a divide cycle in progress is never disturbed.

Top module: `swallow_ctrl`

## Requirements
- R1: While `rst_n` is low, `mod_ctl` and `fv_pulse` are both 0.
- R2: For 0 < A < N, the oscillator-cycle distance between successive `fv_pulse` pulses is N·P + A, where `mod_ctl` = 0 selects prescaler modulus P+1 and `mod_ctl` = 1 selects modulus P.
- R3: Each divide cycle of N prescaled clocks starts with `mod_ctl` low for the first A clocks. `mod_ctl` is then high for the remaining N−A clocks. It falls only when a new cycle starts.
- R4: With A = 0, `mod_ctl` stays high for the whole cycle and the total division is N·P.
- R5: With A ≥ N, `mod_ctl` stays low for the whole cycle and the total division is N·(P+1).
- R6: `fv_pulse` is high for exactly one prescaled clock per cycle, on the last clock of the N count, and is never high on two clocks in a row.
- R7: A programmed N below 3 (0, 1 or 2) is treated as 3.
- R8: A change of `n_prog` or `a_prog` takes effect only at the next reload. The cycle already under way completes with the old values.
- R9: The full range N = 1023, A = 127 divides by 1023·P + 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| n_prog | input | 10 | Main count N (3..1023; lower values clamp to 3) |
| a_prog | input | 7 | Swallow count A (0..127) |
| mod_ctl | output | 1 | Modulus select to the prescaler: 0 selects P+1, 1 selects P |
| fv_pulse | output | 1 | One-clock pulse at the main counter's terminal count |

## Verification
The bench closes the loop with a behavioural prescaler and measures, in oscillator cycles, the distance between feedback pulses and the number of low-modulus slots in each cycle.

- **A = 0:** a design that waits one clock before raising the select line would add one oscillator cycle to every divide.
- **A = N and A > N:** a design that wraps the swallow counter would produce a wrong low-slot count.
- **N of 0 or 1:** without clamping, the design would stall or divide by a tiny ratio.
- **Mid-cycle reprogramming:** a design that takes new values immediately would shorten the cycle under way.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
    localparam int unsigned N_WIDTH = 10;
    localparam int unsigned A_WIDTH = 7;
    localparam int unsigned N_FLOOR = 3;

    typedef struct packed {
        logic mod_sel;
        logic fb_pulse;
    } out_state_t;
endpackage

// File: rtl/swallow_ncount.sv
module swallow_ncount #(
    parameter int unsigned W     = swallow_pkg::N_WIDTH,
    parameter int unsigned FLOOR = swallow_pkg::N_FLOOR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] n_prog,
    output logic         reload_o,
    output logic [W-1:0] nxt_o
);
    localparam logic [W-1:0] MIN_N = W'(FLOOR);
    localparam logic [W-1:0] ONE   = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } nst_t;

    nst_t st_d, st_q;
    logic [W-1:0] n_eff;

    always_comb begin
        n_eff    = (n_prog < MIN_N) ? MIN_N : n_prog;
        reload_o = (st_q.cnt <= ONE);
        st_d     = st_q;
        if (reload_o) begin
            st_d.cnt = n_eff;
        end else begin
            st_d.cnt = st_q.cnt - ONE;
        end
        nxt_o = st_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    n_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt > ONE) |=> (st_q.cnt == $past(st_q.cnt) - ONE));

    // R7
    n_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> (st_q.cnt >= MIN_N));
endmodule

// File: rtl/swallow_acount.sv
module swallow_acount #(
    parameter int unsigned W = swallow_pkg::A_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload_i,
    input  logic [W-1:0] a_prog,
    output logic [W-1:0] nxt_o
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ast_t;

    ast_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reload_i) begin
            st_d.cnt = a_prog;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE;
        end
        nxt_o = st_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    a_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !reload_i) |=> (st_q.cnt == '0));
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl #(
    parameter int unsigned N_W   = swallow_pkg::N_WIDTH,
    parameter int unsigned A_W   = swallow_pkg::A_WIDTH,
    parameter int unsigned N_MIN = swallow_pkg::N_FLOOR
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_prog,
    input  logic [A_W-1:0] a_prog,
    output logic           mod_ctl,
    output logic           fv_pulse
);
    import swallow_pkg::*;

    localparam logic [N_W-1:0] N_LAST = N_W'(1);

    logic           reload;
    logic [N_W-1:0] n_nxt;
    logic [A_W-1:0] a_nxt;
    out_state_t     o_d, o_q;

    swallow_ncount #(.W(N_W), .FLOOR(N_MIN)) u_ncnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .n_prog   (n_prog),
        .reload_o (reload),
        .nxt_o    (n_nxt)
    );

    swallow_acount #(.W(A_W)) u_acnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (reload),
        .a_prog   (a_prog),
        .nxt_o    (a_nxt)
    );

    always_comb begin
        o_d          = o_q;
        o_d.mod_sel  = (a_nxt == '0);
        o_d.fb_pulse = (n_nxt == N_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign mod_ctl  = o_q.mod_sel;
    assign fv_pulse = o_q.fb_pulse;

    // R6
    fv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fv_pulse |=> !fv_pulse);

    // R3
    mod_fall_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_ctl) |-> $past(fv_pulse));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!mod_ctl && !fv_pulse));
endmodule

// File: tb/swallow_ctrl_test.sv
`timescale 1ns/1ps
module swallow_ctrl_test;
    localparam int P = 8;

    logic       vco = 1'b0;
    logic       pre_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] n_set = 10'd10;
    logic [6:0] a_set = 7'd3;
    logic       mod_ctl;
    logic       fv_pulse;

    swallow_ctrl uut (
        .clk      (pre_clk),
        .rst_n    (rst_n),
        .n_prog   (n_set),
        .a_prog   (a_set),
        .mod_ctl  (mod_ctl),
        .fv_pulse (fv_pulse)
    );

    always #2.5 vco = ~vco;

    typedef struct {
        longint ratio;
        int     lows;
        string  tag;
    } exp_t;

    exp_t   q[$];
    int     checks = 0;
    int     fails = 0;
    event   fv_ev;
    longint t = 0;
    longint prev_t = 0;
    bit     have_prev = 0;
    int     low_acc = 0;
    bit     prev_fv = 0;
    bit     fv_double = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: runs at the sample point of each prescaled period
    task automatic sample_point();
        if (rst_n) begin
            if (fv_pulse && prev_fv) fv_double = 1;
            prev_fv = fv_pulse;
            if (fv_pulse) begin
                if (have_prev && q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check((t - prev_t) == e.ratio, e.tag, "division ratio", t - prev_t, e.ratio);
                    check(low_acc == e.lows, e.tag, "low-modulus slots", low_acc, e.lows);
                end
                have_prev = 1;
                prev_t    = t;
                low_acc   = 0;
                -> fv_ev;
            end
            if (!mod_ctl) low_acc++;
        end
    endtask

    // behavioural prescaler: modulus P when mod_ctl high, P+1 when low
    initial begin
        forever begin
            int len;
            @(negedge vco);
            t++;
            pre_clk = 1'b1;
            @(negedge vco);
            t++;
            sample_point();
            pre_clk = 1'b0;
            len = mod_ctl ? P : P + 1;
            repeat (len - 2) begin
                @(negedge vco);
                t++;
            end
        end
    end

    // driver: expected items from the requirements
    task automatic push(input int n, input int a, input string tag);
        int ne;
        int l;
        ne = (n < 3) ? 3 : n;
        l  = (a < ne) ? a : ne;
        q.push_back('{longint'(ne) * P + l, l, tag});
    endtask

    task automatic run_case(input int n, input int a, input string tag);
        @(fv_ev);
        n_set = 10'(n);
        a_set = 7'(a);
        @(fv_ev);
        push(n, a, tag);
        push(n, a, tag);
        @(fv_ev);
        @(fv_ev);
    endtask

    initial begin
        #750000;
        fails++;
        checks++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (40) @(negedge vco);
        #1;
        check(mod_ctl == 1'b0, "R1", "mod_ctl in reset", mod_ctl, 0);
        check(fv_pulse == 1'b0, "R1", "fv_pulse in reset", fv_pulse, 0);
        #1 rst_n = 1'b1;

        run_case(10, 3, "R2/R3");
        run_case(37, 11, "R2");
        run_case(3, 2, "R2");
        run_case(5, 0, "R4");
        run_case(4, 9, "R5");
        run_case(6, 6, "R5");
        run_case(1, 1, "R7");
        run_case(0, 0, "R7");
        run_case(1023, 127, "R9");

        // R8: reprogram in the middle of a cycle
        @(fv_ev);
        n_set = 10'd20;
        a_set = 7'd5;
        @(fv_ev);
        push(20, 5, "R8");
        repeat (5) @(posedge pre_clk);
        #1;
        n_set = 10'd7;
        a_set = 7'd2;
        @(fv_ev);
        @(fv_ev);
        push(7, 2, "R8");
        push(7, 2, "R8");
        @(fv_ev);
        @(fv_ev);

        #20;
        check(q.size() == 0, "R2", "unconsumed expectations", q.size(), 0);
        check(!fv_double, "R6", "fv_pulse consecutive highs", fv_double, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule